// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the pins of a general-purpose I/O port into interrupt requests. It handles each pin separately. Each pin has five control bits: an enable, a mask, a sense select (level or edge), a polarity select, and a debounce select. The pin inputs arrive already synchronized to the block clock. A pin that has debounce selected first passes through a filter. The filter advances only on ticks of a slow clock-enable input.

A level-sensed pin reports its active level while that level is present, and it holds no state. An edge-sensed pin stores a detected edge in a per-pin latch. The latch stays set until software writes a one to that pin's end-of-interrupt bit. Hardware detects only one edge direction per pin. Software gets both-edge behaviour by flipping the polarity bit after each serviced event. For that reason, changing the polarity never creates an event by itself.

The block drives three outputs: the raw per-pin status, the status after masking, and a single interrupt line that is the OR of the masked status.

Top module: `gpio_irq_detect`

## Requirements
- R1: A sense bit of 1 makes the pin edge-sensitive and a sense bit of 0 makes it level-sensitive. An edge seen on the pin sets its raw status bit one clock later.
- R2: A polarity bit of 1 selects a rising edge or an active-high level. A polarity bit of 0 selects a falling edge or an active-low level. The opposite edge produces no event.
- R3: A detected edge event stays set after the pin returns to its old level. It remains set until it is cleared.
- R4: A 1 in an end-of-interrupt bit clears that pin's latched edge at the next clock. A 0 bit leaves the event alone. All ones clears every pending edge.
- R5: A level-sensed pin's raw status follows the pin with no latching. End-of-interrupt bits have no effect on it.
- R6: A mask bit of 1 removes the pin from the masked status and from the interrupt line. The latched edge is kept and reappears when the mask bit returns to 0.
- R7: A pin whose enable bit is 0 shows no status and detects nothing. Clearing the enable also discards its latched edge.
- R8: A change of the polarity bit while the pin is steady creates no edge event.
- R9: When a new edge and an end-of-interrupt clear for the same pin occur in the same cycle, the event stays latched.
- R10: With debounce selected, a new pin value is accepted only after two consecutive debounce ticks have sampled it. A value seen on a single tick is ignored.
- R11: The masked status equals raw status AND NOT mask. The interrupt line is high exactly when any masked status bit is high.
- R12: After reset all raw status, masked status and the interrupt line are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Synchronized pin levels |
| db_tick_i | input | 1 | Debounce clock enable, one cycle per tick |
| en_i | input | NPINS | Per-pin detection enable |
| mask_i | input | NPINS | Per-pin mask, 1 hides the pin |
| sense_i | input | NPINS | 1 = edge, 0 = level |
| pol_i | input | NPINS | 1 = rising/high, 0 = falling/low |
| deb_en_i | input | NPINS | Per-pin debounce select |
| eoi_i | input | NPINS | Write-one-to-clear strobe for latched edges |
| raw_o | output | NPINS | Per-pin status before masking |
| stat_o | output | NPINS | Per-pin status after masking |
| irq_o | output | 1 | Combined interrupt line |

## Verification
A wrong latch state shows up on raw_o in the cycle after the edge or clear that caused it. Depending on the mask, it then reaches stat_o and irq_o in the same cycle. A broken edge history sample is the other internal fault. It shows up as a missing edge or a spurious event one clock after the pin or polarity changes. A debounce filter that takes the wrong value delays or suppresses the event by whole ticks, so it is visible within the next one or two ticks. The directed scenarios sample raw_o, stat_o and irq_o at each of these points.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    typedef struct packed {
        logic   en;
        logic   pol;
        sense_e sense;
    } pin_cfg_t;

    // Edge of the selected direction between the previous and current sample.
    function automatic logic edge_hit(input logic cur, input logic prv, input logic pol);
        return pol ? (cur & ~prv) : (~cur & prv);
    endfunction

    // Active level for a level-sensed pin.
    function automatic logic level_on(input logic cur, input logic pol);
        return pol ? cur : ~cur;
    endfunction

endpackage

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [NPINS-1:0] raw_i,
    input  logic [NPINS-1:0] deb_en_i,
    output logic [NPINS-1:0] pin_o
);

    logic [NPINS-1:0] last_q;
    logic [NPINS-1:0] stable_q;

    // Stable value moves only when two consecutive ticks sampled the same level.
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= '0;
            stable_q <= '0;
        end else if (tick_i) begin
            last_q   <= raw_i;
            stable_q <= (~(raw_i ^ last_q) & raw_i) | ((raw_i ^ last_q) & stable_q);
        end
    end

    assign pin_o = (deb_en_i & stable_q) | (~deb_en_i & raw_i);

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] sel_i,
    input  pin_cfg_t         cfg_i [NPINS],
    input  logic [NPINS-1:0] eoi_i,
    output logic [NPINS-1:0] hit_o,
    output logic [NPINS-1:0] raw_o
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sel_i;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic is_edge;
        assign is_edge  = (cfg_i[g].sense == SENSE_EDGE);
        assign hit_o[g] = edge_hit(sel_i[g], prev_q[g], cfg_i[g].pol);

        // Priority: disable clears, new edge sets, then end-of-interrupt clears.
        always_ff @(posedge clk) begin
            if (rst || !cfg_i[g].en)          latch_q[g] <= 1'b0;
            else if (is_edge && hit_o[g])     latch_q[g] <= 1'b1;
            else if (eoi_i[g])                latch_q[g] <= 1'b0;
        end

        assign raw_o[g] = cfg_i[g].en &
                          (is_edge ? latch_q[g] : level_on(sel_i[g], cfg_i[g].pol));
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_i,
    input  logic             db_tick_i,
    input  logic [NPINS-1:0] en_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic [NPINS-1:0] sense_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] deb_en_i,
    input  logic [NPINS-1:0] eoi_i,
    output logic [NPINS-1:0] raw_o,
    output logic [NPINS-1:0] stat_o,
    output logic             irq_o
);

    logic [NPINS-1:0] pin_sel;
    logic [NPINS-1:0] edge_hit_v;
    pin_cfg_t         cfg [NPINS];

    for (genvar g = 0; g < NPINS; g++) begin : g_cfg
        assign cfg[g].en    = en_i[g];
        assign cfg[g].pol   = pol_i[g];
        assign cfg[g].sense = sense_e'(sense_i[g]);
    end

    gpio_irq_debounce #(.NPINS(NPINS)) u_deb (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (db_tick_i),
        .raw_i    (pin_i),
        .deb_en_i (deb_en_i),
        .pin_o    (pin_sel)
    );

    gpio_irq_edge #(.NPINS(NPINS)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .sel_i (pin_sel),
        .cfg_i (cfg),
        .eoi_i (eoi_i),
        .hit_o (edge_hit_v),
        .raw_o (raw_o)
    );

    assign stat_o = raw_o & ~mask_i;
    assign irq_o  = |stat_o;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] en_i,
    input logic [NPINS-1:0] sense_i,
    input logic [NPINS-1:0] eoi_i,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] raw_o
);

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        a_r3_edge_holds: assert property (@(posedge clk) disable iff (rst)
            (en_i[g] && sense_i[g] && raw_o[g] && !eoi_i[g])
            |=> (!en_i[g] || !sense_i[g] || raw_o[g]));

        a_r4_eoi_clears: assert property (@(posedge clk) disable iff (rst)
            (en_i[g] && sense_i[g] && eoi_i[g] && !hit[g])
            |=> (!en_i[g] || !sense_i[g] || !raw_o[g]));

        a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
            (en_i[g] && sense_i[g] && hit[g])
            |=> (!en_i[g] || !sense_i[g] || raw_o[g]));

        a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
            (en_i[g] && sense_i[g] && !hit[g] && !raw_o[g])
            |=> (!en_i[g] || !sense_i[g] || !raw_o[g]));

        a_r7_disable_drops: assert property (@(posedge clk) disable iff (rst)
            (!en_i[g]) |=> (!en_i[g] || !sense_i[g] || hit[g] || !raw_o[g]));
    end

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .sense_i (sense_i),
    .eoi_i   (eoi_i),
    .hit     (edge_hit_v),
    .raw_o   (raw_o)
);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
    localparam int CLK_P = 10;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] pin, en, mask, sense, pol, deb, eoi;
    logic tick;
    logic [N-1:0] raw, stat;
    logic irq;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_detect #(.NPINS(N)) u0 (
        .clk(clk), .rst(rst), .pin_i(pin), .db_tick_i(tick), .en_i(en),
        .mask_i(mask), .sense_i(sense), .pol_i(pol), .deb_en_i(deb),
        .eoi_i(eoi), .raw_o(raw), .stat_o(stat), .irq_o(irq)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        pin = '0; en = '0; mask = '0; sense = '0; pol = '0; deb = '0; eoi = '0; tick = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 raw", raw, '0);
        chk("R12 stat", stat, '0);
        chk("R12 irq", {31'b0, irq}, '0);
    endtask

    task automatic t_rise();
        do_reset();
        en[0] = 1; sense[0] = 1; pol[0] = 1;
        step(1);
        chk("R1 no event before edge", raw, '0);
        pin[0] = 1;
        step(1);
        chk("R1 rising edge latched", raw, 32'h1);
        pin[0] = 0;
        step(3);
        chk("R3 event held", raw, 32'h1);
        chk("R11 irq on", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_fall();
        do_reset();
        pin[3] = 1;
        step(1);
        en[3] = 1; sense[3] = 1; pol[3] = 0;
        step(2);
        chk("R2 no falling yet", raw, '0);
        pin[3] = 0;
        step(1);
        chk("R2 falling edge", raw, 32'h8);
        eoi[3] = 1; step(1); eoi = '0;
        pin[3] = 1; step(1);
        chk("R2 rising ignored on falling pin", raw, '0);
    endtask

    task automatic t_eoi();
        do_reset();
        en[1:0] = 2'b11; sense[1:0] = 2'b11; pol[1:0] = 2'b11;
        step(1);
        pin[1:0] = 2'b11;
        step(1);
        chk("R4 both latched", raw, 32'h3);
        eoi = 32'h4; step(1); eoi = '0;
        chk("R4 other bit no effect", raw, 32'h3);
        eoi = 32'h1; step(1); eoi = '0;
        chk("R4 single clear", raw, 32'h2);
        eoi = '1; step(1); eoi = '0;
        chk("R4 all ones clear", raw, '0);
    endtask

    task automatic t_level();
        do_reset();
        en[2] = 1; pol[2] = 1;
        step(1);
        chk("R5 level low idle", raw, '0);
        pin[2] = 1; step(1);
        chk("R5 level high tracks", raw, 32'h4);
        eoi = '1; step(1); eoi = '0;
        chk("R5 eoi ignored on level", raw, 32'h4);
        pin[2] = 0; step(1);
        chk("R5 level follows pin low", raw, '0);
        en[4] = 1; pol[4] = 0; step(1);
        chk("R2 active-low level", raw, 32'h10);
    endtask

    task automatic t_mask();
        do_reset();
        en[1] = 1; sense[1] = 1; pol[1] = 1; mask[1] = 1;
        step(1);
        pin[1] = 1; step(1);
        chk("R6 raw kept under mask", raw, 32'h2);
        chk("R6 stat hidden", stat, '0);
        chk("R11 irq off masked", {31'b0, irq}, '0);
        mask[1] = 0; step(1);
        chk("R6 stat after unmask", stat, 32'h2);
        chk("R11 irq after unmask", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_enable();
        do_reset();
        sense[0] = 1; pol[0] = 1;
        step(1);
        pin[0] = 1; step(1);
        chk("R7 disabled no status", raw, '0);
        pin[0] = 0; step(1);
        en[0] = 1; step(2);
        chk("R7 nothing kept while disabled", raw, '0);
        pin[0] = 1; step(1);
        chk("R7 enabled detects", raw, 32'h1);
        en[0] = 0; step(1);
        en[0] = 1; step(1);
        chk("R7 disable dropped latch", raw, '0);
    endtask

    task automatic t_polflip();
        do_reset();
        en[0] = 1; sense[0] = 1; pol[0] = 1;
        step(1);
        pin[0] = 1; step(1);
        eoi[0] = 1; step(1); eoi = '0;
        chk("R4 cleared before flip", raw, '0);
        pol[0] = 0; step(2);
        chk("R8 flip to falling no event", raw, '0);
        pol[0] = 1; step(2);
        chk("R8 flip back no event", raw, '0);
    endtask

    task automatic t_collide();
        do_reset();
        en[0] = 1; sense[0] = 1; pol[0] = 1;
        step(1);
        pin[0] = 1; eoi[0] = 1;
        step(1);
        eoi = '0;
        chk("R9 edge beats clear", raw, 32'h1);
    endtask

    task automatic tick_once();
        tick = 1; step(1); tick = 0; step(1);
    endtask

    task automatic t_debounce();
        do_reset();
        deb[5] = 1; en[5] = 1; sense[5] = 1; pol[5] = 1;
        step(1);
        pin[5] = 1; tick_once();
        pin[5] = 0; tick_once();
        step(1);
        chk("R10 single-tick glitch ignored", raw, '0);
        pin[5] = 1; tick_once();
        chk("R10 one tick not enough", raw, '0);
        tick = 1; step(1); tick = 0;
        step(1);
        chk("R10 accepted after two ticks", raw, 32'h20);
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_eoi();
        t_level();
        t_mask();
        t_enable();
        t_polflip();
        t_collide();
        t_debounce();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule